// File: doc/BRIEF.md
# NAND Flash Bus Command Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. A client hands it one high-level request at a time: page read, spare-area read, page program, block erase, status read, ID read or device reset. Each request carries a 25-bit byte address and, where data moves, a byte count. The sequencer expands the request into a frame of command, address and data bus cycles. It drives the chip enable, the command and address latch strobes, the write and read strobes and the shared I/O lines. For operations that leave the device busy, it waits on the active-low ready/busy line, with a timeout.

Write data is pulled from the client one byte per `wr_take` pulse. Read data is pushed out one byte per `rd_valid` pulse. Completion is a single `done` pulse that carries the status byte read back and a timeout flag. Strobe timing is set by cycle-count parameters: the low width of a strobe (`T_PULSE`), a blanking time before ready/busy is trusted (`T_WB`) and the wait limit (`TIMEOUT`).

Top module: `nand_seq_top`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low on the next cycle. Completion is a one-cycle `done` pulse in the first cycle `req_ready` is high again, so a request held valid is taken in that same cycle. At reset the block is idle with every strobe inactive.
- R2: Every byte sent or read has `nf_ce_n` low. The strobe (`nf_we_n` or `nf_re_n`) is low for exactly `T_PULSE` cycles, with one cycle before and one cycle after it high. The I/O value and the latch strobes stay constant while the strobe is low. The device captures each written byte at the rising edge of `nf_we_n`.
- R3: `nf_cle` is high only on command bytes and `nf_ale` only on address bytes. They are never high together, and both are low on data bytes.
- R4: Page read (`req_op`=3) sends opcode 00h when address bit 8 is 0 and 01h when it is 1. It then sends three address bytes in this order: `addr[7:0]`, `addr[16:9]`, `addr[24:17]`. It waits for ready and then reads `req_len` bytes with `nf_re_n`, each presented once on `rd_valid`/`rd_data`.
- R5: Spare read (`req_op`=4) sends opcode 50h and the column byte `{4'h0, addr[3:0]}`, followed by the same two row bytes, the wait and the data reads as R4.
- R6: Page program (`req_op`=5) sends 80h, the three R4 address bytes, `req_len` data bytes and then 10h. Each data byte is the value on `wr_data` in the cycle `wr_take` pulses. After ready returns, it sends 70h, reads one byte and reports that byte on `done_status`.
- R7: Block erase (`req_op`=6) sends 60h, then only the two row bytes `addr[16:9]` and `addr[24:17]`, then D0h. After ready returns it sends 70h, reads one byte and reports it on `done_status`.
- R8: Status read (`req_op`=1) sends 70h, reads one byte and reports it on `done_status`.
- R9: ID read (`req_op`=2) sends 90h and an address byte of 00h, then reads `req_len` bytes onto `rd_valid`/`rd_data`.
- R10: Reset (`req_op`=0) sends FFh, waits for ready and completes with `done_timeout` low.
- R11: If `nf_rb_n` has not been seen high within `TIMEOUT` cycles of the start of a wait, the block completes with `done_timeout` high and issues no further bus cycle of that frame.
- R12: `req_valid` and `req_op` are ignored while a frame is in progress. No extra frame and no extra completion results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 3 | Operation: 0 reset, 1 status, 2 ID, 3 page read, 4 spare read, 5 program, 6 erase |
| req_addr | input | 25 | Byte address |
| req_len | input | LEN_W | Number of data bytes to read or write |
| wr_data | input | 8 | Program data byte offered to the sequencer |
| wr_take | output | 1 | Pulse: `wr_data` is taken this cycle |
| rd_valid | output | 1 | Pulse: `rd_data` holds a read byte |
| rd_data | output | 8 | Byte read from the device |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Status byte read back (0 when none) |
| done_timeout | output | 1 | Completion was caused by the busy timeout |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | I/O bus value driven by the host |
| nf_io_oe | output | 1 | Host drives the I/O bus |
| nf_io_in | input | 8 | I/O bus value from the device |
| nf_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
Completion of one frame and acceptance of the next can happen in the same cycle. The `done` pulse appears in the first idle cycle, and a request held valid is taken on that edge. The bench keeps `req_valid` high across two status reads. It requires that `req_ready` was high in the cycle `done` pulsed, that the first `done_status` is intact, and that a second 70h frame follows with no idle gap. A second pairing is a request arriving while a frame runs. The bench drives one in the middle of an erase and expects the bus log to show no extra frame and the completion count to show no extra `done`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_W = 25;
    localparam int STEP_W = 4;

    typedef enum logic [2:0] {
        OP_RESET  = 3'd0,
        OP_STATUS = 3'd1,
        OP_ID     = 3'd2,
        OP_READ   = 3'd3,
        OP_SPARE  = 3'd4,
        OP_PROG   = 3'd5,
        OP_ERASE  = 3'd6
    } op_e;

    // Kind of bus step in a frame
    typedef enum logic [2:0] {
        K_CMD,
        K_ADDR,
        K_WR,
        K_RD,
        K_STAT,
        K_WAIT,
        K_END
    } kind_e;

    localparam logic [7:0] OPC_RD_LO   = 8'h00;
    localparam logic [7:0] OPC_RD_HI   = 8'h01;
    localparam logic [7:0] OPC_SPARE   = 8'h50;
    localparam logic [7:0] OPC_ID      = 8'h90;
    localparam logic [7:0] OPC_RESET   = 8'hFF;
    localparam logic [7:0] OPC_PROG    = 8'h80;
    localparam logic [7:0] OPC_PROG_GO = 8'h10;
    localparam logic [7:0] OPC_ERASE   = 8'h60;
    localparam logic [7:0] OPC_ERA_GO  = 8'hD0;
    localparam logic [7:0] OPC_STATUS  = 8'h70;

endpackage

// File: rtl/nand_seq_frame.sv
// Frame table: for an operation, its address and a step index, give the
// kind of bus step and the byte it carries.
module nand_seq_frame
    import nand_seq_pkg::*;
(
    input  op_e                      op_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [STEP_W-1:0]        step_i,
    output kind_e                    kind_o,
    output logic [7:0]               byte_o
);

    logic [7:0] col_b;
    logic [7:0] row_lo_b;
    logic [7:0] row_hi_b;
    logic [7:0] spare_col_b;
    logic [7:0] read_opc;

    // Bit 8 picks the page half through the opcode and is never sent.
    assign col_b       = addr_i[7:0];
    assign row_lo_b    = addr_i[16:9];
    assign row_hi_b    = addr_i[24:17];
    assign spare_col_b = {4'h0, addr_i[3:0]};
    assign read_opc    = addr_i[8] ? OPC_RD_HI : OPC_RD_LO;

    always_comb begin
        kind_o = K_END;
        byte_o = 8'h00;
        case (op_i)
            OP_READ, OP_SPARE: begin
                case (step_i)
                    4'd0: begin
                        kind_o = K_CMD;
                        byte_o = (op_i == OP_SPARE) ? OPC_SPARE : read_opc;
                    end
                    4'd1: begin
                        kind_o = K_ADDR;
                        byte_o = (op_i == OP_SPARE) ? spare_col_b : col_b;
                    end
                    4'd2: begin kind_o = K_ADDR; byte_o = row_lo_b; end
                    4'd3: begin kind_o = K_ADDR; byte_o = row_hi_b; end
                    4'd4: kind_o = K_WAIT;
                    4'd5: kind_o = K_RD;
                    default: kind_o = K_END;
                endcase
            end
            OP_PROG: begin
                case (step_i)
                    4'd0: begin kind_o = K_CMD;  byte_o = OPC_PROG;    end
                    4'd1: begin kind_o = K_ADDR; byte_o = col_b;       end
                    4'd2: begin kind_o = K_ADDR; byte_o = row_lo_b;    end
                    4'd3: begin kind_o = K_ADDR; byte_o = row_hi_b;    end
                    4'd4: kind_o = K_WR;
                    4'd5: begin kind_o = K_CMD;  byte_o = OPC_PROG_GO; end
                    4'd6: kind_o = K_WAIT;
                    4'd7: begin kind_o = K_CMD;  byte_o = OPC_STATUS;  end
                    4'd8: kind_o = K_STAT;
                    default: kind_o = K_END;
                endcase
            end
            OP_ERASE: begin
                case (step_i)
                    4'd0: begin kind_o = K_CMD;  byte_o = OPC_ERASE;   end
                    4'd1: begin kind_o = K_ADDR; byte_o = row_lo_b;    end
                    4'd2: begin kind_o = K_ADDR; byte_o = row_hi_b;    end
                    4'd3: begin kind_o = K_CMD;  byte_o = OPC_ERA_GO;  end
                    4'd4: kind_o = K_WAIT;
                    4'd5: begin kind_o = K_CMD;  byte_o = OPC_STATUS;  end
                    4'd6: kind_o = K_STAT;
                    default: kind_o = K_END;
                endcase
            end
            OP_STATUS: begin
                case (step_i)
                    4'd0: begin kind_o = K_CMD; byte_o = OPC_STATUS; end
                    4'd1: kind_o = K_STAT;
                    default: kind_o = K_END;
                endcase
            end
            OP_ID: begin
                case (step_i)
                    4'd0: begin kind_o = K_CMD;  byte_o = OPC_ID; end
                    4'd1: begin kind_o = K_ADDR; byte_o = 8'h00;  end
                    4'd2: kind_o = K_RD;
                    default: kind_o = K_END;
                endcase
            end
            OP_RESET: begin
                case (step_i)
                    4'd0: begin kind_o = K_CMD; byte_o = OPC_RESET; end
                    4'd1: kind_o = K_WAIT;
                    default: kind_o = K_END;
                endcase
            end
            default: kind_o = K_END;
        endcase
    end

endmodule

// File: rtl/nand_seq_timer.sv
// Wait timer: counts while a wait step is active, reports when the
// ready/busy blanking time has passed and when the wait limit is reached.
module nand_seq_timer #(
    parameter int T_WB    = 2,
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic settled_o,
    output logic expired_o
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(TIMEOUT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign settled_o = (cnt_q >= CW'(T_WB));
    assign expired_o = (cnt_q == CW'(TIMEOUT));

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int T_PULSE = 2,
    parameter int T_WB    = 2,
    parameter int TIMEOUT = 4096,
    parameter int LEN_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [7:0]         wr_data,
    output logic               wr_take,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               done,
    output logic [7:0]         done_status,
    output logic               done_timeout,
    output logic               nf_ce_n,
    output logic               nf_cle,
    output logic               nf_ale,
    output logic               nf_we_n,
    output logic               nf_re_n,
    output logic [7:0]         nf_io_out,
    output logic               nf_io_oe,
    input  logic [7:0]         nf_io_in,
    input  logic               nf_rb_n
);

    // One bus beat: setup, T_PULSE strobe-low cycles, hold.
    localparam int BEAT_LEN = T_PULSE + 2;
    localparam int CNT_W    = $clog2(BEAT_LEN);

    typedef enum logic {S_IDLE, S_RUN} st_e;

    typedef struct packed {
        st_e                st;
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   nbyte;
        logic [STEP_W-1:0]  step;
        logic [CNT_W-1:0]   cnt;
        logic [7:0]         wbuf;
        logic [7:0]         status;
        logic [7:0]         rd_data;
        logic               rd_valid;
        logic               done;
        logic               timeout;
    } state_t;

    state_t r_d, r_q;

    kind_e      kind;
    logic [7:0] frame_byte;
    logic       run;
    logic       is_out;
    logic       is_in;
    logic       data_kind;
    logic       skip_data;
    logic       beat_last;
    logic       strobe_win;
    logic       sample_now;
    logic       wait_settled;
    logic       wait_expired;

    nand_seq_frame u_frame (
        .op_i   (r_q.op),
        .addr_i (r_q.addr),
        .step_i (r_q.step),
        .kind_o (kind),
        .byte_o (frame_byte)
    );

    nand_seq_timer #(
        .T_WB    (T_WB),
        .TIMEOUT (TIMEOUT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run && (kind == K_WAIT)),
        .settled_o (wait_settled),
        .expired_o (wait_expired)
    );

    assign run        = (r_q.st == S_RUN);
    assign is_out     = (kind == K_CMD) || (kind == K_ADDR) || (kind == K_WR);
    assign is_in      = (kind == K_RD) || (kind == K_STAT);
    assign data_kind  = (kind == K_WR) || (kind == K_RD);
    assign skip_data  = data_kind && (r_q.len == '0);
    assign beat_last  = (r_q.cnt == CNT_W'(BEAT_LEN - 1));
    assign strobe_win = (r_q.cnt != '0) && (r_q.cnt <= CNT_W'(T_PULSE));
    assign sample_now = (r_q.cnt == CNT_W'(T_PULSE));

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rd_valid = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st      = S_RUN;
                    r_d.op      = op_e'(req_op);
                    r_d.addr    = req_addr;
                    r_d.len     = req_len;
                    r_d.step    = '0;
                    r_d.cnt     = '0;
                    r_d.nbyte   = '0;
                    r_d.status  = 8'h00;
                    r_d.timeout = 1'b0;
                end
            end
            default: begin
                if (kind == K_END) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else if (kind == K_WAIT) begin
                    // Ready wins over an expiry that lands in the same cycle.
                    if (wait_settled && nf_rb_n) begin
                        r_d.step = r_q.step + 1'b1;
                    end else if (wait_expired) begin
                        r_d.timeout = 1'b1;
                        r_d.st      = S_IDLE;
                        r_d.done    = 1'b1;
                    end
                end else if (skip_data) begin
                    r_d.step = r_q.step + 1'b1;
                end else begin
                    if ((kind == K_WR) && (r_q.cnt == '0)) begin
                        r_d.wbuf = wr_data;
                    end
                    if (is_in && sample_now) begin
                        if (kind == K_RD) begin
                            r_d.rd_valid = 1'b1;
                            r_d.rd_data  = nf_io_in;
                        end else begin
                            r_d.status = nf_io_in;
                        end
                    end
                    if (beat_last) begin
                        r_d.cnt = '0;
                        if (data_kind && (r_q.nbyte != r_q.len - 1'b1)) begin
                            r_d.nbyte = r_q.nbyte + 1'b1;
                        end else begin
                            r_d.nbyte = '0;
                            r_d.step  = r_q.step + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = !run;
    assign done         = r_q.done;
    assign done_status  = r_q.status;
    assign done_timeout = r_q.timeout;
    assign rd_valid     = r_q.rd_valid;
    assign rd_data      = r_q.rd_data;
    assign wr_take      = run && (kind == K_WR) && !skip_data && (r_q.cnt == '0);

    assign nf_ce_n   = !run;
    assign nf_cle    = run && (kind == K_CMD);
    assign nf_ale    = run && (kind == K_ADDR);
    assign nf_we_n   = !(run && is_out && !skip_data && strobe_win);
    assign nf_re_n   = !(run && is_in && !skip_data && strobe_win);
    assign nf_io_oe  = run && is_out;

    always_comb begin
        nf_io_out = 8'h00;
        if (run && is_out) begin
            if (kind == K_WR) begin
                nf_io_out = (r_q.cnt == '0) ? wr_data : r_q.wbuf;
            end else begin
                nf_io_out = frame_byte;
            end
        end
    end

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_io_out,
    input logic       nf_io_oe
);

    a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    a_r2_ce_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    a_r2_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    a_r2_io_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n && $past(!nf_we_n)) |->
            ($stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale)));

    a_r2_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> nf_io_oe);

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nf_ce_n && nf_we_n && nf_re_n));

endmodule

bind nand_seq_top nand_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_io_out (nf_io_out),
    .nf_io_oe  (nf_io_oe)
);

// File: tb/nand_seq_top_tb_top.sv
module nand_seq_top_tb_top;

    localparam int T_PULSE = 2;
    localparam int T_WB    = 2;
    localparam int TIMEOUT = 300;
    localparam int LEN_W   = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_op = 3'd0;
    logic [24:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0]       wr_data;
    logic             wr_take;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic             done;
    logic [7:0]       done_status;
    logic             done_timeout;
    logic             nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]       nf_io_out;
    logic [7:0]       nf_io_in;
    logic             nf_rb_n;

    always #10 clk = ~clk;

    nand_seq_top #(
        .T_PULSE (T_PULSE),
        .T_WB    (T_WB),
        .TIMEOUT (TIMEOUT),
        .LEN_W   (LEN_W)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .wr_data      (wr_data),
        .wr_take      (wr_take),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .done         (done),
        .done_status  (done_status),
        .done_timeout (done_timeout),
        .nf_ce_n      (nf_ce_n),
        .nf_cle       (nf_cle),
        .nf_ale       (nf_ale),
        .nf_we_n      (nf_we_n),
        .nf_re_n      (nf_re_n),
        .nf_io_out    (nf_io_out),
        .nf_io_oe     (nf_io_oe),
        .nf_io_in     (nf_io_in),
        .nf_rb_n      (nf_rb_n)
    );

    // ---------------- device model and monitors ----------------
    logic [9:0] bus_log [512];
    int         log_n = 0;
    logic [7:0] rd_log [256];
    int         rd_n = 0;
    int         done_cnt = 0;
    logic [7:0] last_status = 8'h00;
    logic       last_to = 1'b0;
    logic       done_rdy = 1'b0;
    int         wr_idx = 0;
    int         busy_len = 20;
    int         busy_left = 0;
    int         we_bad = 0;
    int         wlow = 0;
    int         rd_idx = 0;
    int         addr_cnt = 0;
    logic       rd_cmd = 1'b0;
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] stat_val = 8'hC0;
    logic       prev_we = 1'b1;
    logic       prev_re = 1'b1;

    assign wr_data  = 8'(wr_idx * 7 + 3);
    assign nf_rb_n  = (busy_left == 0);
    assign nf_io_in = (last_cmd == 8'h70) ? stat_val : (8'(rd_idx) ^ 8'h5A);

    always @(posedge clk) begin
        prev_we <= nf_we_n;
        prev_re <= nf_re_n;
        if (wr_take) wr_idx <= wr_idx + 1;
        if (rd_valid) begin
            rd_log[rd_n % 256] <= rd_data;
            rd_n <= rd_n + 1;
        end
        if (done) begin
            done_cnt    <= done_cnt + 1;
            last_status <= done_status;
            last_to     <= done_timeout;
            done_rdy    <= req_ready;
        end
        if (!nf_we_n) wlow <= wlow + 1;
        if (!prev_re && nf_re_n) rd_idx <= rd_idx + 1;
        if (!prev_we && nf_we_n) begin
            bus_log[log_n % 512] <= {nf_cle, nf_ale, nf_io_out};
            log_n <= log_n + 1;
            if (wlow != T_PULSE) we_bad <= we_bad + 1;
            wlow <= 0;
            if (nf_cle) begin
                last_cmd <= nf_io_out;
                rd_idx   <= 0;
                addr_cnt <= 0;
                rd_cmd   <= (nf_io_out == 8'h00) || (nf_io_out == 8'h01) ||
                            (nf_io_out == 8'h50);
            end
            if (nf_cle && ((nf_io_out == 8'h10) || (nf_io_out == 8'hD0) ||
                           (nf_io_out == 8'hFF))) begin
                busy_left <= busy_len;
            end else if (nf_ale && rd_cmd && (addr_cnt == 2)) begin
                busy_left <= busy_len;
                rd_cmd    <= 1'b0;
            end else if (busy_left > 0) begin
                busy_left <= busy_left - 1;
            end
            if (nf_ale) addr_cnt <= addr_cnt + 1;
        end else if (busy_left > 0) begin
            busy_left <= busy_left - 1;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fail = 0;
    logic [9:0] exp_q [16];
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [24:0] mk_addr(input logic [7:0] rhi, input logic [7:0] rlo,
                                            input logic half, input logic [7:0] col);
        return {rhi, rlo, half, col};
    endfunction

    function automatic logic [9:0] c_b(input logic [7:0] b); return {2'b10, b}; endfunction
    function automatic logic [9:0] a_b(input logic [7:0] b); return {2'b01, b}; endfunction
    function automatic logic [9:0] d_b(input logic [7:0] b); return {2'b00, b}; endfunction

    task automatic issue(input logic [2:0] op, input logic [24:0] a, input int len);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op    = op;
        req_addr  = a;
        req_len   = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int start, input string req);
        int k = 0;
        while (done_cnt <= start && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(done_cnt > start, req, "completion seen", done_cnt, start + 1);
    endtask

    task automatic check_frame(input int base, input int nexp, input string req);
        bit ok = (log_n - base) == nexp;
        chk(ok, req, "bus byte count", log_n - base, nexp);
        if (ok) begin
            for (int i = 0; i < nexp; i++) begin
                logic [9:0] got = bus_log[(base + i) % 512];
                chk(got == exp_q[i], req, $sformatf("bus byte %0d {cle,ale,io}", i),
                    int'(got), int'(exp_q[i]));
            end
        end
    endtask

    task automatic check_reads(input int base, input int len, input string req);
        chk((rd_n - base) == len, req, "read byte count", rd_n - base, len);
        for (int i = 0; i < len && i < (rd_n - base); i++) begin
            chk(rd_log[(base + i) % 256] == (8'(i) ^ 8'h5A), req,
                $sformatf("read byte %0d", i), int'(rd_log[(base + i) % 256]),
                int'(8'(i) ^ 8'h5A));
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(req_ready && nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !done,
            "R1", "idle after reset {rdy,ce_n,we_n,re_n,cle,ale,done}",
            int'({req_ready, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, done}), 'h78);
    endtask

    task automatic t_page_read(input logic half, input string req);
        int lb = log_n, rb = rd_n, db = done_cnt;
        logic [24:0] a = mk_addr(8'h3C, 8'hA7, half, 8'h15);
        issue(3'd3, a, 4);
        wait_done(db, req);
        exp_q[0] = c_b(half ? 8'h01 : 8'h00);
        exp_q[1] = a_b(8'h15);
        exp_q[2] = a_b(8'hA7);
        exp_q[3] = a_b(8'h3C);
        check_frame(lb, 4, req);
        check_reads(rb, 4, req);
        chk(!last_to, req, "no timeout", int'(last_to), 0);
    endtask

    task automatic t_spare_read();
        int lb = log_n, rb = rd_n, db = done_cnt;
        logic [24:0] a = mk_addr(8'h81, 8'h42, 1'b0, 8'hEB);
        issue(3'd4, a, 2);
        wait_done(db, "R5");
        exp_q[0] = c_b(8'h50);
        exp_q[1] = a_b(8'h0B);
        exp_q[2] = a_b(8'h42);
        exp_q[3] = a_b(8'h81);
        check_frame(lb, 4, "R5");
        check_reads(rb, 2, "R5");
    endtask

    task automatic t_program();
        int lb = log_n, db = done_cnt, wb = wr_idx;
        logic [24:0] a = mk_addr(8'h05, 8'hFE, 1'b0, 8'h20);
        stat_val = 8'hE0;
        issue(3'd5, a, 3);
        wait_done(db, "R6");
        exp_q[0] = c_b(8'h80);
        exp_q[1] = a_b(8'h20);
        exp_q[2] = a_b(8'hFE);
        exp_q[3] = a_b(8'h05);
        for (int i = 0; i < 3; i++) exp_q[4 + i] = d_b(8'((wb + i) * 7 + 3));
        exp_q[7] = c_b(8'h10);
        exp_q[8] = c_b(8'h70);
        check_frame(lb, 9, "R6");
        chk(last_status == 8'hE0, "R6", "program status", int'(last_status), 'hE0);
        chk(wr_idx - wb == 3, "R6", "bytes taken", wr_idx - wb, 3);
    endtask

    task automatic t_erase();
        int lb = log_n, db = done_cnt;
        logic [24:0] a = mk_addr(8'h7F, 8'h60, 1'b1, 8'h99);
        stat_val = 8'hC1;
        issue(3'd6, a, 0);
        wait_done(db, "R7");
        exp_q[0] = c_b(8'h60);
        exp_q[1] = a_b(8'h60);
        exp_q[2] = a_b(8'h7F);
        exp_q[3] = c_b(8'hD0);
        exp_q[4] = c_b(8'h70);
        check_frame(lb, 5, "R7");
        chk(last_status == 8'hC1, "R7", "erase status", int'(last_status), 'hC1);
    endtask

    task automatic t_status();
        int lb = log_n, db = done_cnt;
        stat_val = 8'h9A;
        issue(3'd1, '0, 0);
        wait_done(db, "R8");
        exp_q[0] = c_b(8'h70);
        check_frame(lb, 1, "R8");
        chk(last_status == 8'h9A, "R8", "status byte", int'(last_status), 'h9A);
    endtask

    task automatic t_read_id();
        int lb = log_n, rb = rd_n, db = done_cnt;
        issue(3'd2, 25'h1ABCDE, 2);
        wait_done(db, "R9");
        exp_q[0] = c_b(8'h90);
        exp_q[1] = a_b(8'h00);
        check_frame(lb, 2, "R9");
        check_reads(rb, 2, "R9");
    endtask

    task automatic t_dev_reset();
        int lb = log_n, db = done_cnt;
        issue(3'd0, '0, 0);
        wait_done(db, "R10");
        exp_q[0] = c_b(8'hFF);
        check_frame(lb, 1, "R10");
        chk(!last_to, "R10", "reset without timeout", int'(last_to), 0);
    endtask

    task automatic t_timeout();
        int lb = log_n, db = done_cnt;
        busy_len = 1000;
        issue(3'd6, mk_addr(8'h11, 8'h22, 1'b0, 8'h00), 0);
        wait_done(db, "R11");
        chk(last_to, "R11", "timeout flag", int'(last_to), 1);
        exp_q[0] = c_b(8'h60);
        exp_q[1] = a_b(8'h22);
        exp_q[2] = a_b(8'h11);
        exp_q[3] = c_b(8'hD0);
        repeat (20) @(negedge clk);
        check_frame(lb, 4, "R11");
        chk(nf_ce_n, "R11", "chip enable released", int'(nf_ce_n), 1);
        busy_len = 20;
        repeat (1100) @(negedge clk);
    endtask

    task automatic t_ignore_busy();
        int lb = log_n, db = done_cnt;
        stat_val = 8'hC0;
        issue(3'd6, mk_addr(8'h44, 8'h55, 1'b0, 8'h00), 0);
        @(negedge clk);
        req_op    = 3'd0;
        req_valid = 1'b1;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        wait_done(db, "R12");
        repeat (30) @(negedge clk);
        chk(done_cnt == db + 1, "R12", "single completion", done_cnt, db + 1);
        exp_q[0] = c_b(8'h60);
        exp_q[1] = a_b(8'h55);
        exp_q[2] = a_b(8'h44);
        exp_q[3] = c_b(8'hD0);
        exp_q[4] = c_b(8'h70);
        check_frame(lb, 5, "R12");
    endtask

    task automatic t_back_to_back();
        int lb = log_n, db = done_cnt;
        int k = 0;
        stat_val = 8'h5C;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op    = 3'd1;
        req_valid = 1'b1;
        while (done_cnt <= db && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(done_rdy, "R1", "ready in done cycle", int'(done_rdy), 1);
        chk(last_status == 8'h5C, "R1", "first status kept", int'(last_status), 'h5C);
        chk(!req_ready, "R1", "next request taken at done", int'(req_ready), 0);
        req_valid = 1'b0;
        wait_done(db + 1, "R1");
        exp_q[0] = c_b(8'h70);
        exp_q[1] = c_b(8'h70);
        check_frame(lb, 2, "R1");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_page_read(1'b0, "R4");
        t_page_read(1'b1, "R4");
        t_spare_read();
        t_program();
        t_erase();
        t_status();
        t_read_id();
        t_dev_reset();
        t_timeout();
        t_ignore_busy();
        t_back_to_back();
        chk(we_bad == 0, "R2", "strobe low width mismatches", we_bad, 0);
        chk(log_n > 0, "R3", "latch flags recorded with bus bytes", log_n, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule